// File: doc/BRIEF.md
# Glitch-Free Reference Clock Ratio Divider

This block turns a reference clock into a slower clock for an external processor. Four divide ratios are available, two of them odd, and a 2-bit code picks one. A host may load a new code at any moment. The block puts the new ratio into use only at the start of an output period. Every high phase and every low phase on the output therefore has the full length of one ratio, and no shortened pulse can reach the processor.

Reset selects the slowest ratio, so that a processor that can only run slowly at low supply voltage starts at a safe rate. With a 12 MHz reference the four ratios give 6.0, 4.0, 2.4 and 1.2 MHz. The output comes straight from a flip-flop that runs on rising reference edges only.

The code is loaded through a one-cycle strobe, and the port stays plain control. There is no data stream and no back-pressure.

Top module: `refclk_ratio_div`

## Requirements
- R1: The select code sets the output period in reference cycles: code 0 (binary 00) gives 2, code 1 (01) gives 3, code 2 (10) gives 5 and code 3 (11) gives 10.
- R2: For an even ratio N the output is high for N/2 reference cycles, then low for N/2 cycles.
- R3: For an odd ratio N the output is high for (N-1)/2 reference cycles, then low for (N+1)/2 cycles.
- R4: While the synchronous active-high reset is asserted, the output is low and code 3 (divide by 10) is selected. The first rising reference edge after reset is released drives the output high. The first period after reset is 10 cycles long.
- R5: A code presented with `sel_wr` high is captured on that rising edge. It governs only the output periods that begin on a later rising edge. The period already under way finishes with its old high and low widths, so no phase is ever cut short.
- R6: A change on `sel_in` while `sel_wr` is low has no effect on the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; all logic uses its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sel_wr | input | 1 | Strobe that loads `sel_in` into the pending-select register |
| sel_in | input | 2 | Ratio code: 0 = /2, 1 = /3, 2 = /5, 3 = /10 |
| clk_out | output | 1 | Divided clock, driven directly from a flip-flop |

## Verification
The bench measures the width of every high phase and every low phase in reference cycles. Each width is compared with the ratio that should govern that period, which covers both the odd-ratio split and the even-ratio split. A table steps through every code, including each transition between an odd and an even ratio and from the slowest ratio to the fastest. Each write falls at a pseudo-random offset inside the current period, so the test shows whether the switch waits for a period boundary or cuts a phase short. Directed cases check the reset state and the first period after reset, a reset issued during fast operation, and `sel_in` toggling with no strobe, which must leave the period unchanged.

// File: rtl/ckdiv_pkg.sv
package ckdiv_pkg;
  localparam int unsigned SEL_W      = 2;
  localparam int unsigned NUM_RATIOS = 1 << SEL_W;
  typedef logic [SEL_W-1:0] sel_t;
  // slowest ratio is the highest code
  localparam sel_t SEL_RESET = sel_t'(NUM_RATIOS - 1);
endpackage

// File: rtl/ckdiv_sel_shadow.sv
module ckdiv_sel_shadow
  import ckdiv_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  sel_t wr_sel,
  input  logic take,
  output sel_t active_sel
);
  sel_t pending_q;
  sel_t active_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending_q <= SEL_RESET;
      active_q  <= SEL_RESET;
    end else begin
      if (wr_en) pending_q <= wr_sel;
      if (take)  active_q  <= pending_q;
    end
  end

  assign active_sel = active_q;

  AST_PENDING_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> pending_q == $past(wr_sel)); // R5
  AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !take |=> active_q == $past(active_q)); // R5
  AST_IGNORE_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> pending_q == $past(pending_q)); // R6
endmodule

// File: rtl/ckdiv_ratio_lut.sv
module ckdiv_ratio_lut
  import ckdiv_pkg::*;
#(
  parameter int unsigned DIV_0 = 2,
  parameter int unsigned DIV_1 = 3,
  parameter int unsigned DIV_2 = 5,
  parameter int unsigned DIV_3 = 10,
  parameter int unsigned CNT_W = 4
) (
  input  sel_t             sel,
  output logic [CNT_W-1:0] last_idx,
  output logic [CNT_W-1:0] high_len
);
  localparam int unsigned DIVS [NUM_RATIOS] = '{DIV_0, DIV_1, DIV_2, DIV_3};

  logic [CNT_W-1:0] last_tab [NUM_RATIOS];
  logic [CNT_W-1:0] high_tab [NUM_RATIOS];

  for (genvar g = 0; g < NUM_RATIOS; g++) begin : g_entry
    // the shorter half goes high, so odd ratios have the longer phase low
    assign last_tab[g] = CNT_W'(DIVS[g] - 1);
    assign high_tab[g] = CNT_W'(DIVS[g] / 2);
  end

  assign last_idx = last_tab[sel];
  assign high_len = high_tab[sel];
endmodule

// File: rtl/ckdiv_phase_gen.sv
module ckdiv_phase_gen #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] last_idx,
  input  logic [CNT_W-1:0] high_len,
  output logic             period_start,
  output logic             clk_out
);
  // cnt 0 is the final low cycle; 1..high_len are high; the rest are low
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             out_d;

  always_comb begin
    if (cnt_q == last_idx) cnt_d = '0;
    else                   cnt_d = cnt_q + CNT_W'(1);
    out_d = (cnt_d != '0) && (cnt_d <= high_len);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      clk_out <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      clk_out <= out_d;
    end
  end

  assign period_start = (cnt_q == '0);

  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == last_idx) |=> cnt_q == '0); // R1
  AST_RISE_AT_START: assert property (@(posedge clk) disable iff (rst)
    $rose(clk_out) |-> $past(cnt_q) == '0); // R1
  AST_FALL_AFTER_HIGH: assert property (@(posedge clk) disable iff (rst)
    $fell(clk_out) |-> $past(cnt_q) == $past(high_len)); // R2
  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= last_idx); // R3
endmodule

// File: rtl/refclk_ratio_div.sv
module refclk_ratio_div
  import ckdiv_pkg::*;
#(
  parameter int unsigned DIV_0 = 2,
  parameter int unsigned DIV_1 = 3,
  parameter int unsigned DIV_2 = 5,
  parameter int unsigned DIV_3 = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sel_wr,
  input  logic [1:0] sel_in,
  output logic       clk_out
);
  localparam int unsigned MAX_01  = (DIV_0 > DIV_1) ? DIV_0 : DIV_1;
  localparam int unsigned MAX_23  = (DIV_2 > DIV_3) ? DIV_2 : DIV_3;
  localparam int unsigned DIV_MAX = (MAX_01 > MAX_23) ? MAX_01 : MAX_23;
  localparam int unsigned CNT_W   = $clog2(DIV_MAX);

  sel_t             active_sel;
  logic             period_start;
  logic [CNT_W-1:0] last_idx;
  logic [CNT_W-1:0] high_len;

  ckdiv_sel_shadow u_shadow (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (sel_wr),
    .wr_sel     (sel_in),
    .take       (period_start),
    .active_sel (active_sel)
  );

  ckdiv_ratio_lut #(
    .DIV_0 (DIV_0), .DIV_1 (DIV_1), .DIV_2 (DIV_2), .DIV_3 (DIV_3), .CNT_W (CNT_W)
  ) u_lut (
    .sel      (active_sel),
    .last_idx (last_idx),
    .high_len (high_len)
  );

  ckdiv_phase_gen #(.CNT_W (CNT_W)) u_phase (
    .clk          (clk),
    .rst          (rst),
    .last_idx     (last_idx),
    .high_len     (high_len),
    .period_start (period_start),
    .clk_out      (clk_out)
  );

  AST_OUT_LOW_AFTER_RESET: assert property (@(posedge clk)
    $past(rst) && rst |-> !clk_out); // R4
endmodule

// File: tb/refclk_ratio_div_tb_top.sv
module refclk_ratio_div_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sel_wr = 1'b0;
  logic [1:0] sel_in = 2'd0;
  logic       clk_out;

  always #4 clk = ~clk;  // 125 MHz

  refclk_ratio_div dut_i (
    .clk (clk), .rst (rst), .sel_wr (sel_wr), .sel_in (sel_in), .clk_out (clk_out)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit done     = 0;

  // monitor state
  bit       prev_out  = 0;
  bit       in_period = 0;
  int       hcnt = 0, lcnt = 0;
  int       cur_code = 3, per_code = 3, prev_per_code = 3;
  bit       pend = 0;
  int       pend_code = 0, pend_edge = 0;
  int       last_n = 0;
  logic [7:0] lfsr = 8'hA5;

  // {code, expected period}
  localparam logic [5:0] VEC [10] = '{
    {2'd0, 4'd2}, {2'd1, 4'd3}, {2'd2, 4'd5}, {2'd3, 4'd10}, {2'd0, 4'd2},
    {2'd2, 4'd5}, {2'd1, 4'd3}, {2'd3, 4'd10}, {2'd1, 4'd3}, {2'd0, 4'd2}
  };

  function automatic int exp_n(input int code);
    case (code)
      0: return 2;
      1: return 3;
      2: return 5;
      default: return 10;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  // phase-width monitor, sampled mid-cycle
  always @(negedge clk) begin
    if (rst) begin
      in_period = 0; cur_code = 3; pend = 0; hcnt = 0; lcnt = 0;
    end else if (clk_out && !prev_out) begin
      if (in_period) begin
        if (per_code != prev_per_code) begin
          check(hcnt == exp_n(per_code) / 2, "R5 high", hcnt, exp_n(per_code) / 2);
          check(lcnt == exp_n(per_code) - exp_n(per_code) / 2, "R5 low", lcnt,
                exp_n(per_code) - exp_n(per_code) / 2);
        end else if (exp_n(per_code) % 2 == 0) begin
          check(hcnt == exp_n(per_code) / 2, "R2 high", hcnt, exp_n(per_code) / 2);
          check(lcnt == exp_n(per_code) / 2, "R2 low", lcnt, exp_n(per_code) / 2);
        end else begin
          check(hcnt == (exp_n(per_code) - 1) / 2, "R3 high", hcnt, (exp_n(per_code) - 1) / 2);
          check(lcnt == (exp_n(per_code) + 1) / 2, "R3 low", lcnt, (exp_n(per_code) + 1) / 2);
        end
        last_n = hcnt + lcnt;
        prev_per_code = per_code;
      end else begin
        prev_per_code = cur_code;
      end
      if (pend && pend_edge < cyc) begin
        cur_code = pend_code;
        pend = 0;
      end
      per_code = cur_code;
      in_period = 1; hcnt = 1; lcnt = 0;
    end else if (clk_out) begin
      hcnt++;
    end else begin
      lcnt++;
    end
    prev_out = clk_out;
  end

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_sel(input int code);
    sel_in    = 2'(code);
    sel_wr    = 1'b1;
    pend_code = code;
    pend_edge = cyc + 1;
    pend      = 1;
    @(negedge clk);
    sel_wr = 1'b0;
  endtask

  initial begin
    // R4: reset state and first period
    wait_cycles(4);
    check(clk_out == 1'b0, "R4 out low in reset", clk_out, 0);
    rst = 1'b0;
    @(negedge clk);
    check(clk_out == 1'b1, "R4 rise on first edge", clk_out, 1);
    wait_cycles(30);
    check(last_n == 10, "R4 first period", last_n, 10);

    // R1: table of codes, each written at a pseudo-random offset
    for (int i = 0; i < 10; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      wait_cycles(int'(lfsr[2:0]) + 11);
      write_sel(int'(VEC[i][5:4]));
      wait_cycles(30);
      check(last_n == int'(VEC[i][3:0]), "R1 period", last_n, int'(VEC[i][3:0]));
    end

    // R6: sel_in moves without a strobe
    wait_cycles(12);
    write_sel(3);
    wait_cycles(25);
    sel_in = 2'd0;
    wait_cycles(15);
    sel_in = 2'd1;
    wait_cycles(25);
    check(last_n == 10, "R6 no strobe", last_n, 10);

    // R4: reset during fast operation
    write_sel(0);
    wait_cycles(20);
    rst = 1'b1;
    wait_cycles(3);
    check(clk_out == 1'b0, "R4 mid-run reset low", clk_out, 0);
    rst = 1'b0;
    @(negedge clk);
    check(clk_out == 1'b1, "R4 restart rise", clk_out, 1);
    wait_cycles(30);
    check(last_n == 10, "R4 default after reset", last_n, 10);

    // R5: writes at every offset within a slow period
    for (int k = 0; k < 10; k++) begin
      wait_cycles(11 + k);
      write_sel((k % 2 == 0) ? 1 : 3);
      wait_cycles(12);
    end
    wait_cycles(30);
    check(last_n == 10, "R5 final ratio", last_n, 10);

    finish_run();
  end
endmodule